// File: doc/BRIEF.md
# Radix-8 Iterative Floating-Point Divider

This block divides one normalized single-precision number by another. It is built for the last stage of a small projective transform. There, the first two components of a matrix-vector product are each divided by the third component. A sequencer pulses `start` with an operand pair. The block raises `busy`, spends nine clocks developing the quotient, and then pulses `done` with the packed result.

Each clock retires a three-bit quotient digit. The digit comes from comparing the shifted partial remainder against all seven nonzero multiples of the divisor at once. Nine digits give 27 quotient bits. These cover the 24 significand bits plus one extra bit for the single normalizing shift. The result is truncated and is never rounded.

Inputs are treated as normalized values only. The one special case handled is a zero operand, which is any operand whose exponent field is zero. A zero divisor is flagged.

Top module: `fp_div_r8`

## Requirements
- R1: Operands and result use the single-precision layout: sign in bit 31, biased exponent in bits 30:23 (bias 127), fraction in bits 22:0 with a hidden leading one. The result sign is the XOR of the two operand signs, including for zero and divide-by-zero results.
- R2: When the dividend significand is at least the divisor significand, the result exponent is the dividend exponent minus the divisor exponent plus 127. The fraction is the 23 bits that follow the leading one of the significand quotient.
- R3: When the dividend significand is below the divisor significand, the quotient is shifted left by one bit and the exponent from R2 is reduced by one.
- R4: The fraction is the exact quotient truncated toward zero, with no rounding (for example, 1.0/3.0 gives 0x3EAAAAAA).
- R5: A divisor with a zero exponent field sets `div_by_zero` for that result. The result then has exponent 0xFF and fraction 0, whatever the dividend is.
- R6: A zero dividend (exponent field 0) with a nonzero divisor gives a signed zero with `div_by_zero` low.
- R7: A start accepted on a clock edge raises `busy` from that edge. `done` pulses for exactly one cycle, nine edges after the accepting edge, and `busy` drops on that same edge.
- R8: `start` while `busy` is high is ignored. It neither produces an extra result nor disturbs the operation in flight.
- R9: A new start may be accepted on the edge right after `done` rises, so operand pairs can be issued every ten clocks.
- R10: After reset, `busy`, `done`, `quotient` and `div_by_zero` are all zero, and `quotient` holds its last value between results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to divide; taken when not busy |
| dividend | input | 32 | Numerator, single precision |
| divisor | input | 32 | Denominator, single precision |
| busy | output | 1 | Divide in progress |
| done | output | 1 | One-cycle pulse: result valid |
| quotient | output | 32 | Truncated single-precision quotient |
| div_by_zero | output | 1 | Divisor was zero for this result |

## Verification
Each result is due on the ninth rising edge after the edge that accepts `start`. A new operation can be accepted on the tenth edge. When the driver raises `start`, it records the edge count at which acceptance will occur. It then queues the expected value with a due cycle nine edges later. The monitor samples at falling edges and compares both the value and the cycle in which `done` appeared, so a result that arrives early or late fails even if its value is correct. Back-to-back issues check the ten-clock spacing. A start that is dropped mid-operation must not create an extra `done`.

// File: rtl/fp_div_r8_pkg.sv
package fp_div_r8_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } div_state_e;

   // number of digit iterations needed for a significand of sig_w bits plus
   // one normalization bit when each iteration retires digit_bits bits
   function automatic int unsigned iter_count(input int unsigned sig_w,
                                              input int unsigned digit_bits);
      return (sig_w + 1 + digit_bits - 1) / digit_bits;
   endfunction

endpackage

// File: rtl/fp_div_r8_unpack.sv
module fp_div_r8_unpack #(
   parameter int unsigned EXP_W = 8,
   parameter int unsigned MAN_W = 23
) (
   input  logic [EXP_W+MAN_W:0] word_i,
   output logic                 sign_o,
   output logic [EXP_W-1:0]     exp_o,
   output logic [MAN_W:0]       sig_o,
   output logic                 zero_o
);

   always_comb begin
      sign_o = word_i[EXP_W+MAN_W];
      exp_o  = word_i[EXP_W+MAN_W-1 -: EXP_W];
      zero_o = (exp_o == '0);
      sig_o  = {1'b1, word_i[MAN_W-1:0]};
   end

endmodule

// File: rtl/fp_div_r8_step.sv
module fp_div_r8_step #(
   parameter int unsigned REM_W        = 28,
   parameter int unsigned DIGIT_BITS   = 3,
   parameter bit          USE_POPCOUNT = 1'b1
) (
   input  logic [REM_W-1:0]      rem_i,
   input  logic [REM_W-1:0]      dvs_i,
   output logic [DIGIT_BITS-1:0] digit_o,
   output logic [REM_W-1:0]      rem_o
);

   localparam int unsigned NMUL = (1 << DIGIT_BITS) - 1;

   logic [REM_W-1:0] shifted;
   logic [REM_W-1:0] mult [0:NMUL];
   logic [NMUL:1]    ge;

   assign shifted = rem_i << DIGIT_BITS;

   // all divisor multiples and their comparisons, evaluated side by side
   for (genvar k = 0; k <= NMUL; k++) begin : g_mult
      assign mult[k] = dvs_i * REM_W'(k);
      if (k > 0) begin : g_cmp
         assign ge[k] = (shifted >= mult[k]);
      end
   end

   // ge is a thermometer code; two equivalent ways to turn it into a digit
   if (USE_POPCOUNT) begin : g_sel_pop
      always_comb digit_o = DIGIT_BITS'($countones(ge));
   end else begin : g_sel_pri
      always_comb begin
         digit_o = '0;
         for (int k = 1; k <= int'(NMUL); k++) begin
            if (ge[k]) digit_o = DIGIT_BITS'(k);
         end
      end
   end

   assign rem_o = shifted - mult[digit_o];

endmodule

// File: rtl/fp_div_r8_pack.sv
module fp_div_r8_pack #(
   parameter int unsigned EXP_W = 8,
   parameter int unsigned MAN_W = 23,
   parameter int unsigned Q_W   = 27
) (
   input  logic                 sign_i,
   input  logic [EXP_W-1:0]     ea_i,
   input  logic [EXP_W-1:0]     eb_i,
   input  logic                 a_zero_i,
   input  logic                 b_zero_i,
   input  logic [Q_W-1:0]       q_i,
   output logic [EXP_W+MAN_W:0] res_o,
   output logic                 dbz_o
);

   localparam int unsigned EW2  = EXP_W + 2;
   localparam int unsigned BIAS = (1 << (EXP_W - 1)) - 1;

   logic             q_hi;
   logic [EW2-1:0]   e_full;
   logic [MAN_W-1:0] frac;

   assign q_hi = q_i[Q_W-1];

   always_comb begin
      e_full = {2'b00, ea_i} - {2'b00, eb_i} + EW2'(BIAS) - EW2'(!q_hi);
      frac   = q_hi ? q_i[Q_W-2 -: MAN_W] : q_i[Q_W-3 -: MAN_W];
   end

   always_comb begin
      dbz_o = b_zero_i;
      if (b_zero_i)
         res_o = {sign_i, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
      else if (a_zero_i)
         res_o = {sign_i, {(EXP_W + MAN_W){1'b0}}};
      else
         res_o = {sign_i, e_full[EXP_W-1:0], frac};
   end

endmodule

// File: rtl/fp_div_r8.sv
module fp_div_r8 #(
   parameter int unsigned EXP_W        = 8,
   parameter int unsigned MAN_W        = 23,
   parameter int unsigned DIGIT_BITS   = 3,
   parameter bit          USE_POPCOUNT = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [EXP_W+MAN_W:0] dividend,
   input  logic [EXP_W+MAN_W:0] divisor,
   output logic                 busy,
   output logic                 done,
   output logic [EXP_W+MAN_W:0] quotient,
   output logic                 div_by_zero
);

   import fp_div_r8_pkg::*;

   localparam int unsigned SIG_W = MAN_W + 1;
   localparam int unsigned ITER  = iter_count(SIG_W, DIGIT_BITS);
   localparam int unsigned Q_W   = ITER * DIGIT_BITS;
   localparam int unsigned REM_W = SIG_W + 1 + DIGIT_BITS;
   localparam int unsigned CNT_W = (ITER > 1) ? $clog2(ITER) : 1;
   localparam int unsigned W     = EXP_W + MAN_W + 1;

   if (DIGIT_BITS < 1 || DIGIT_BITS > 4) begin : g_bad_digit
      $error("fp_div_r8: DIGIT_BITS must lie in 1..4");
   end
   if (EXP_W < 3 || MAN_W < 4) begin : g_bad_fmt
      $error("fp_div_r8: exponent or fraction field too narrow");
   end
   if (Q_W < SIG_W + 1) begin : g_bad_q
      $error("fp_div_r8: quotient lacks a normalization bit");
   end

   logic             sa, sb, za, zb;
   logic [EXP_W-1:0] ea, eb;
   logic [MAN_W:0]   siga, sigb;

   fp_div_r8_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) unpack_a_i (
      .word_i(dividend), .sign_o(sa), .exp_o(ea), .sig_o(siga), .zero_o(za));
   fp_div_r8_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) unpack_b_i (
      .word_i(divisor), .sign_o(sb), .exp_o(eb), .sig_o(sigb), .zero_o(zb));

   div_state_e       state;
   logic [CNT_W-1:0] cnt;
   logic [REM_W-1:0] rem_q, dvs_q, rem_d;
   logic [Q_W-1:0]   q_acc, q_next;
   logic [DIGIT_BITS-1:0] digit;
   logic             l_sign, l_za, l_zb;
   logic [EXP_W-1:0] l_ea, l_eb;
   logic [W-1:0]     res_d;
   logic             dbz_d;

   fp_div_r8_step #(.REM_W(REM_W), .DIGIT_BITS(DIGIT_BITS),
                    .USE_POPCOUNT(USE_POPCOUNT)) step_i (
      .rem_i(rem_q), .dvs_i(dvs_q), .digit_o(digit), .rem_o(rem_d));

   if (Q_W > DIGIT_BITS) begin : g_acc_shift
      assign q_next = {q_acc[Q_W-DIGIT_BITS-1:0], digit};
   end else begin : g_acc_single
      assign q_next = Q_W'(digit);
   end

   fp_div_r8_pack #(.EXP_W(EXP_W), .MAN_W(MAN_W), .Q_W(Q_W)) pack_i (
      .sign_i(l_sign), .ea_i(l_ea), .eb_i(l_eb), .a_zero_i(l_za),
      .b_zero_i(l_zb), .q_i(q_next), .res_o(res_d), .dbz_o(dbz_d));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         cnt         <= '0;
         rem_q       <= '0;
         dvs_q       <= '0;
         q_acc       <= '0;
         l_sign      <= 1'b0;
         l_za        <= 1'b0;
         l_zb        <= 1'b0;
         l_ea        <= '0;
         l_eb        <= '0;
         done        <= 1'b0;
         quotient    <= '0;
         div_by_zero <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  state  <= ST_RUN;
                  cnt    <= '0;
                  rem_q  <= REM_W'(siga);
                  dvs_q  <= REM_W'({sigb, 1'b0});
                  q_acc  <= '0;
                  l_sign <= sa ^ sb;
                  l_za   <= za;
                  l_zb   <= zb;
                  l_ea   <= ea;
                  l_eb   <= eb;
               end
            end
            ST_RUN: begin
               rem_q <= rem_d;
               q_acc <= q_next;
               cnt   <= cnt + 1'b1;
               if (cnt == CNT_W'(ITER - 1)) begin
                  state       <= ST_IDLE;
                  done        <= 1'b1;
                  quotient    <= res_d;
                  div_by_zero <= dbz_d;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state == ST_RUN);

endmodule

// File: rtl/fp_div_r8_chk.sv
module fp_div_r8_chk #(
   parameter int unsigned EXP_W      = 8,
   parameter int unsigned MAN_W      = 23,
   parameter int unsigned DIGIT_BITS = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 start,
   input logic                 busy,
   input logic                 done,
   input logic [EXP_W+MAN_W:0] quotient,
   input logic                 div_by_zero
);

   localparam int unsigned ITER  = fp_div_r8_pkg::iter_count(MAN_W + 1, DIGIT_BITS);
   localparam int unsigned RCW   = $clog2(ITER + 2);

   logic [RCW-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              run_cnt <= '0;
      else if (!busy && start) run_cnt <= '0;
      else if (busy)           run_cnt <= run_cnt + 1'b1;
   end

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (busy || done));

   // R7
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (run_cnt == RCW'(ITER) && !busy));

   // R8
   ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && run_cnt < RCW'(ITER - 1)) |=> (busy && !done));

   // R9
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy);

   // R5
   dbz_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && div_by_zero) |->
         (quotient[EXP_W+MAN_W-1 -: EXP_W] == {EXP_W{1'b1}}
          && quotient[MAN_W-1:0] == '0));

endmodule

bind fp_div_r8 fp_div_r8_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W),
                               .DIGIT_BITS(DIGIT_BITS)) chk_i (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .quotient(quotient), .div_by_zero(div_by_zero));

// File: tb/fp_div_r8_tb_top.sv
module fp_div_r8_tb_top;

   typedef struct {
      logic [31:0] val;
      logic        dbz;
      int          due;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] dividend = '0;
   logic [31:0] divisor = '0;
   logic        busy, done, div_by_zero;
   logic [31:0] quotient;

   int   total = 0;
   int   bad = 0;
   int   cyc = 0;
   bit   ended = 1'b0;
   exp_t sb_q[$];

   always #2 clk = ~clk;

   fp_div_r8 dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
      .divisor(divisor), .busy(busy), .done(done), .quotient(quotient),
      .div_by_zero(div_by_zero));

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   // reference model written from the requirements
   function automatic void model(input logic [31:0] a, input logic [31:0] b,
                                 output logic [31:0] r, output logic dbz);
      logic   s;
      longint sa, sbg, qq;
      int     e;
      bit     hi;
      logic [22:0] f;
      s   = a[31] ^ b[31];
      dbz = 1'b0;
      if (b[30:23] == 8'h00) begin
         r   = {s, 8'hFF, 23'h0};
         dbz = 1'b1;
      end else if (a[30:23] == 8'h00) begin
         r = {s, 31'h0};
      end else begin
         sa  = longint'({1'b1, a[22:0]});
         sbg = longint'({1'b1, b[22:0]});
         qq  = (sa << 26) / sbg;
         hi  = (qq >= (64'sd1 <<< 26));
         e   = int'(a[30:23]) - int'(b[30:23]) + 127 - (hi ? 0 : 1);
         f   = hi ? 23'(qq >> 3) : 23'(qq >> 2);
         r   = {s, 8'(e), f};
      end
   endfunction

   task automatic issue(input logic [31:0] a, input logic [31:0] b,
                        input string tag);
      exp_t it;
      @(negedge clk);
      while (busy) @(negedge clk);
      dividend = a;
      divisor  = b;
      start    = 1'b1;
      model(a, b, it.val, it.dbz);
      it.due = cyc + 1 + 9;
      it.tag = tag;
      sb_q.push_back(it);
      @(negedge clk);
      start = 1'b0;
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sb_q.size() == 0) begin
            check(1'b0, "R8", "unexpected done", 1, 0);
         end else begin
            exp_t it;
            it = sb_q.pop_front();
            check(quotient == it.val && div_by_zero == it.dbz, it.tag,
                  "result", {div_by_zero, quotient}, {it.dbz, it.val});
            check(cyc == it.due, "R7", "done cycle", cyc, it.due);
         end
      end
   end

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: run hung, actual=0 expected=1");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      check(!busy && !done && quotient == 0 && !div_by_zero, "R10",
            "reset state", {busy, done, div_by_zero, quotient}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      issue(32'h40C00000, 32'h40400000, "R2");   // 6/3 = 2
      issue(32'h3F800000, 32'h40400000, "R4");   // 1/3 truncated
      issue(32'h3F800000, 32'h3FC00000, "R3");   // 1/1.5
      issue(32'hC0000000, 32'h40000000, "R1");   // -2/2
      issue(32'hC1200000, 32'hC0A00000, "R1");   // -10/-5
      issue(32'h3FFFFFFF, 32'h3F800000, "R2");   // max significand / 1
      issue(32'h3F800000, 32'h3FFFFFFF, "R3");   // 1 / max significand
      issue(32'h00000000, 32'hC0400000, "R6");   // 0 / -3
      issue(32'h3F800000, 32'h00000000, "R5");   // 1/0
      issue(32'h80000000, 32'h00000000, "R5");   // -0/0
      issue(32'h42F60000, 32'h42F60000, "R2");   // x/x = 1

      // R9 back-to-back issues are spaced ten clocks by the due check
      for (int i = 0; i < 40; i++) begin
         logic [31:0] a, b;
         a = {$urandom_range(0, 1) == 1, 8'($urandom_range(90, 160)),
              23'($urandom)};
         b = {$urandom_range(0, 1) == 1, 8'($urandom_range(90, 160)),
              23'($urandom)};
         issue(a, b, (a[22:0] < b[22:0]) ? "R3" : "R2");
      end

      // R8: start while busy must be ignored
      issue(32'h41000000, 32'h40000000, "R8");
      for (int k = 0; k < 3; k++) begin
         check(busy, "R7", "busy during divide", busy, 1);
         @(negedge clk);
      end
      dividend = 32'h3F800000;
      divisor  = 32'h00000000;
      start    = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy, "R8", "busy after ignored start", busy, 1);
      while (sb_q.size() != 0) @(negedge clk);
      repeat (15) @(negedge clk);
      check(!busy && !done, "R8", "idle after ignored start",
            {busy, done}, 0);
      check(quotient == 32'h40800000 && !div_by_zero, "R10",
            "result held", quotient, 32'h40800000);
      finish_run();
   end

endmodule